// File: doc/BRIEF.md
# Posted Control-Register Write Bridge

This block sits between a fast CPU-side register interface and a slow, separately clocked timing domain. A CPU write to one of the slow-domain control registers is captured into a one-deep posting slot and handed across the clock boundary. The CPU does not wait for it. For each target register the block shows two status flags. The pending flag says the slot is still occupied and will refuse another write. The synced flag says the last written value has taken effect and can be read back through the CPU-side mirror.

The slow side picks up a posted value and applies it on the next slow tick. It then reports the completion back across the boundary. All crossings use toggle request/acknowledge pairs through multi-flop synchronizers. The multi-bit payload is only sampled while it is known to be stable. A rising synced flag sets a sticky per-register interrupt bit, which stays set until the CPU clears it. Writes to different registers proceed independently of each other.

Top module: `posted_write_sync`

## Requirements
- R1: During and after reset, every `wr_synced` bit is 1, every `wr_pending` bit is 0, `sync_irq` and `wr_reject` are 0, and every mirror and slow-side value equals `RESET_VAL`.
- R2: A write to register index i is accepted when `wr_pending[i]` is 0. Register i is addressed by `wr_addr` == i. One clock after an accepted write, `wr_pending[i]` is 1 and `wr_synced[i]` is 0.
- R3: A write to register i while `wr_pending[i]` is 1 is dropped and never reaches the slow side. `wr_reject` is 1 for exactly the one clock that follows it.
- R4: `wr_pending[i]` returns to 0 once the slow domain has captured the data. `wr_synced[i]` is still 0 at that point.
- R5: The slow side changes `slow_value` and pulses `slow_apply` only in a cycle where `slow_tick` is high. A captured value waits without limit for a tick, and `wr_synced` stays low while it waits.
- R6: The CPU-side mirror of register i takes the applied value in the same cycle that `wr_synced[i]` rises.
- R7: A rising `wr_synced[i]` sets `sync_irq[i]`. The bit stays set until `irq_clr[i]` is 1 for one clock, and clearing one bit leaves the other bits alone.
- R8: A pending or in-flight write on one register neither blocks nor delays a write to another register.
- R9: A write accepted after capture but before completion of the previous one keeps `wr_synced[i]` low. It stays low until the newer value is applied, and then the mirror shows the newer value.
- R10: A write whose `wr_addr` is `NUM_REGS` or above changes no flag and raises no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | CPU-side active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | ADDR_W | Target register index |
| wr_data | input | DATA_W | Write data |
| irq_clr | input | NUM_REGS | Clear the sticky sync interrupt bit per register |
| wr_pending | output | NUM_REGS | Posting slot occupied per register |
| wr_synced | output | NUM_REGS | Last written value visible per register |
| mirror_flat | output | NUM_REGS*DATA_W | CPU-side readback of the applied values |
| sync_irq | output | NUM_REGS | Sticky interrupt bits set on a synced rise |
| wr_reject | output | 1 | One-clock pulse after a refused write |
| slow_clk | input | 1 | Slow-domain clock |
| slow_rst_n | input | 1 | Slow-domain active-low reset |
| slow_tick | input | 1 | Slow-domain apply enable |
| slow_value_flat | output | NUM_REGS*DATA_W | Applied register values in the slow domain |
| slow_apply | output | NUM_REGS | One slow clock pulse when a value is applied |

## Verification
The assertions assume a few things about the inputs:
- `wr_en` is driven synchronously to `cpu_clk`.
- Both resets are asserted together at start-up.
- `slow_tick` is synchronous to `slow_clk`.
- The clocks are unrelated but both free-running, so a handshake always completes.

The stimulus changes CPU inputs only on falling `cpu_clk` edges and generates ticks from a counter in the slow domain. It gates the ticks off to hold a captured write in the slow domain, which is how the refusal, tick-wait and queued-write cases are set up.

// File: rtl/pws_pkg.sv
package pws_pkg;
   // Smallest synchronizer depth the block will elaborate with.
   localparam int PWS_MIN_STAGES = 2;

   // Bits needed to index n registers (at least one).
   function automatic int pws_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pws_sync_bit.sv
module pws_sync_bit #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < pws_pkg::PWS_MIN_STAGES) begin : g_bad_depth
         $error("pws_sync_bit: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pws_cpu_slot.sv
module pws_cpu_slot #(
   parameter int          DATA_W    = 16,
   parameter int          STAGES    = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_clr,
   input  logic              cap_tgl_a,
   input  logic              done_tgl_a,
   input  logic [DATA_W-1:0] applied_a,
   output logic              pending,
   output logic              synced,
   output logic [DATA_W-1:0] mirror,
   output logic              irq,
   output logic              reject,
   output logic              req_tgl,
   output logic [DATA_W-1:0] slot_data
);
   logic cap_s, done_s, cap_seen, done_seen;
   logic launched, inflight;
   logic cap_evt, done_evt, queued, accept, launch, rise_evt;

   pws_sync_bit #(.STAGES(STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .d(cap_tgl_a), .q(cap_s));
   pws_sync_bit #(.STAGES(STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_tgl_a), .q(done_s));

   assign cap_evt  = cap_s  ^ cap_seen;
   assign done_evt = done_s ^ done_seen;
   // A write sits in the slot but has not been launched yet.
   assign queued   = pending & ~launched;
   assign accept   = wr_hit & ~pending;
   assign launch   = queued & ~inflight;
   assign rise_evt = done_evt & ~queued & ~accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_seen  <= 1'b0;
         done_seen <= 1'b0;
         pending   <= 1'b0;
         synced    <= 1'b1;
         launched  <= 1'b0;
         inflight  <= 1'b0;
         req_tgl   <= 1'b0;
         slot_data <= RESET_VAL;
         mirror    <= RESET_VAL;
         irq       <= 1'b0;
         reject    <= 1'b0;
      end else begin
         cap_seen  <= cap_s;
         done_seen <= done_s;
         reject    <= wr_hit & pending;

         if (accept) begin
            slot_data <= wr_data;
            pending   <= 1'b1;
         end else if (cap_evt) begin
            pending <= 1'b0;
         end

         if (launch) begin
            req_tgl  <= ~req_tgl;
            launched <= 1'b1;
         end else if (cap_evt) begin
            launched <= 1'b0;
         end

         if (launch)        inflight <= 1'b1;
         else if (done_evt) inflight <= 1'b0;

         if (done_evt) mirror <= applied_a;

         if (accept)        synced <= 1'b0;
         else if (rise_evt) synced <= 1'b1;

         if (rise_evt)     irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end

   AST_PEND_NOT_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !synced); // R2
   AST_FULL_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && pending) |=> $stable(slot_data)); // R3
   AST_RISE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> irq); // R7
   AST_MIRROR_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mirror) |-> $past(inflight)); // R6
endmodule

// File: rtl/pws_slow_port.sv
module pws_slow_port #(
   parameter int          DATA_W    = 16,
   parameter int          STAGES    = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_tgl_a,
   input  logic [DATA_W-1:0] slot_data_a,
   input  logic              tick,
   output logic              cap_tgl,
   output logic              done_tgl,
   output logic [DATA_W-1:0] applied,
   output logic              apply_pulse
);
   logic              req_s, req_seen, req_evt, apply_pend;
   logic [DATA_W-1:0] hold_q;

   pws_sync_bit #(.STAGES(STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl_a), .q(req_s));

   assign req_evt = req_s ^ req_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen    <= 1'b0;
         cap_tgl     <= 1'b0;
         done_tgl    <= 1'b0;
         apply_pend  <= 1'b0;
         hold_q      <= RESET_VAL;
         applied     <= RESET_VAL;
         apply_pulse <= 1'b0;
      end else begin
         req_seen    <= req_s;
         apply_pulse <= 1'b0;
         if (req_evt) begin
            hold_q     <= slot_data_a;
            cap_tgl    <= ~cap_tgl;
            apply_pend <= 1'b1;
         end else if (apply_pend && tick) begin
            applied     <= hold_q;
            done_tgl    <= ~done_tgl;
            apply_pend  <= 1'b0;
            apply_pulse <= 1'b1;
         end
      end
   end

   AST_APPLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      apply_pulse |-> $past(tick)); // R5
   AST_WAIT_FOR_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_pend && !tick) |=> (apply_pend && $stable(applied))); // R5
endmodule

// File: rtl/posted_write_sync.sv
module posted_write_sync #(
   parameter int NUM_REGS    = 2,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                       cpu_clk,
   input  logic                       cpu_rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [NUM_REGS-1:0]        irq_clr,
   output logic [NUM_REGS-1:0]        wr_pending,
   output logic [NUM_REGS-1:0]        wr_synced,
   output logic [NUM_REGS*DATA_W-1:0] mirror_flat,
   output logic [NUM_REGS-1:0]        sync_irq,
   output logic                       wr_reject,
   input  logic                       slow_clk,
   input  logic                       slow_rst_n,
   input  logic                       slow_tick,
   output logic [NUM_REGS*DATA_W-1:0] slow_value_flat,
   output logic [NUM_REGS-1:0]        slow_apply
);
   localparam int IDX_W = pws_pkg::pws_idx_w(NUM_REGS);

   generate
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("posted_write_sync: ADDR_W too narrow for NUM_REGS");
      end
      if (SYNC_STAGES < pws_pkg::PWS_MIN_STAGES) begin : g_bad_sync
         $error("posted_write_sync: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [NUM_REGS-1:0] hit, rej, req_tgl, cap_tgl, done_tgl;
   logic [DATA_W-1:0]   slot_data [NUM_REGS];
   logic [DATA_W-1:0]   applied   [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign hit[i] = wr_en & (wr_addr == ADDR_W'(i));

      pws_cpu_slot #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL(RESET_VAL)) u_slot (
         .clk(cpu_clk), .rst_n(cpu_rst_n),
         .wr_hit(hit[i]), .wr_data(wr_data), .irq_clr(irq_clr[i]),
         .cap_tgl_a(cap_tgl[i]), .done_tgl_a(done_tgl[i]), .applied_a(applied[i]),
         .pending(wr_pending[i]), .synced(wr_synced[i]),
         .mirror(mirror_flat[i*DATA_W +: DATA_W]), .irq(sync_irq[i]),
         .reject(rej[i]), .req_tgl(req_tgl[i]), .slot_data(slot_data[i]));

      pws_slow_port #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL(RESET_VAL)) u_port (
         .clk(slow_clk), .rst_n(slow_rst_n),
         .req_tgl_a(req_tgl[i]), .slot_data_a(slot_data[i]), .tick(slow_tick),
         .cap_tgl(cap_tgl[i]), .done_tgl(done_tgl[i]),
         .applied(applied[i]), .apply_pulse(slow_apply[i]));

      assign slow_value_flat[i*DATA_W +: DATA_W] = applied[i];
   end

   assign wr_reject = |rej;

   AST_REJECT_HAS_CAUSE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      wr_reject |-> $past(wr_en && (int'(wr_addr) < NUM_REGS))); // R3
   AST_OUT_OF_RANGE_QUIET: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> (!wr_reject && ($past(wr_pending) == wr_pending || !$stable(wr_pending) == 1'b0) || (wr_pending & ~$past(wr_pending)) == '0)); // R10
   AST_ONE_REJECT_SOURCE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
      $onehot0(rej)); // R8
endmodule

// File: tb/posted_write_sync_bench.sv
module posted_write_sync_bench;
   localparam int N  = 2;
   localparam int DW = 16;
   localparam int AW = 4;

   logic          cpu_clk = 0, slow_clk = 0;
   logic          cpu_rst_n = 0, slow_rst_n = 0;
   logic          wr_en = 0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [N-1:0]  irq_clr = '0;
   logic [N-1:0]  wr_pending, wr_synced, sync_irq, slow_apply;
   logic [N*DW-1:0] mirror_flat, slow_value_flat;
   logic          wr_reject;
   logic          slow_tick = 0, tick_en = 0;
   logic [1:0]    tcnt = '0;
   int            checks = 0, fails = 0;

   always #5  cpu_clk  = ~cpu_clk;
   always #13 slow_clk = ~slow_clk;

   always @(posedge slow_clk) begin
      tcnt      <= tcnt + 2'd1;
      slow_tick <= tick_en && (tcnt == 2'd3);
   end

   posted_write_sync #(.NUM_REGS(N), .DATA_W(DW), .ADDR_W(AW)) u_posted_write_sync (
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_clr(irq_clr), .wr_pending(wr_pending),
      .wr_synced(wr_synced), .mirror_flat(mirror_flat), .sync_irq(sync_irq),
      .wr_reject(wr_reject), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
      .slow_tick(slow_tick), .slow_value_flat(slow_value_flat), .slow_apply(slow_apply));

   function automatic logic [DW-1:0] mir(input int i);
      return mirror_flat[i*DW +: DW];
   endfunction
   function automatic logic [DW-1:0] sval(input int i);
      return slow_value_flat[i*DW +: DW];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge cpu_clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge cpu_clk);
      wr_en = 0;
   endtask

   task automatic wait_pending_low(input int i);
      int n = 0;
      while (wr_pending[i] && n < 400) begin @(negedge cpu_clk); n++; end
      chk(!wr_pending[i], "R4 pending clear", 32'(wr_pending[i]), 0);
   endtask

   task automatic wait_synced(input int i);
      int n = 0;
      while (!wr_synced[i] && n < 400) begin @(negedge cpu_clk); n++; end
      chk(wr_synced[i], "R6 synced rise", 32'(wr_synced[i]), 1);
   endtask

   task automatic t_reset;
      chk(wr_synced == 2'b11, "R1 synced", 32'(wr_synced), 3);
      chk(wr_pending == 2'b00, "R1 pending", 32'(wr_pending), 0);
      chk(sync_irq == 2'b00 && !wr_reject, "R1 irq/reject", 32'({sync_irq, wr_reject}), 0);
      chk(mirror_flat == '0 && slow_value_flat == '0, "R1 values", mirror_flat, 0);
   endtask

   task automatic t_basic;
      tick_en = 1;
      do_write(4'd0, 16'h1234);
      chk(wr_pending[0] && !wr_synced[0], "R2 posted flags", 32'({wr_pending[0], wr_synced[0]}), 2);
      chk(wr_synced[1] && !wr_pending[1], "R8 other untouched", 32'({wr_pending[1], wr_synced[1]}), 1);
      wait_pending_low(0);
      chk(!wr_synced[0], "R4 synced still low", 32'(wr_synced[0]), 0);
      wait_synced(0);
      chk(mir(0) == 16'h1234, "R6 mirror at rise", 32'(mir(0)), 32'h1234);
      chk(sync_irq[0], "R7 irq set", 32'(sync_irq[0]), 1);
      chk(sval(0) == 16'h1234, "R5 slow applied", 32'(sval(0)), 32'h1234);
   endtask

   task automatic t_reject;
      tick_en = 0;
      do_write(4'd1, 16'hAAAA);
      chk(!wr_reject, "R3 first accepted", 32'(wr_reject), 0);
      do_write(4'd1, 16'h5555);
      chk(wr_reject && wr_pending[1], "R3 refused", 32'({wr_reject, wr_pending[1]}), 3);
      @(negedge cpu_clk);
      chk(!wr_reject, "R3 one-cycle pulse", 32'(wr_reject), 0);
      tick_en = 1;
      wait_synced(1);
      chk(mir(1) == 16'hAAAA && sval(1) == 16'hAAAA, "R3 dropped data", 32'(sval(1)), 32'hAAAA);
   endtask

   task automatic t_tick_hold;
      tick_en = 0;
      do_write(4'd0, 16'h0F0F);
      wait_pending_low(0);
      do_write(4'd1, 16'h7777);
      chk(wr_pending[1] && !wr_reject, "R8 independent accept", 32'({wr_pending[1], wr_reject}), 2);
      repeat (60) @(negedge cpu_clk);
      chk(!wr_synced[0] && sval(0) == 16'h1234, "R5 waits for tick", 32'(sval(0)), 32'h1234);
      tick_en = 1;
      wait_synced(0);
      wait_synced(1);
      chk(mir(0) == 16'h0F0F && mir(1) == 16'h7777, "R8 both applied", mirror_flat, {16'h7777, 16'h0F0F});
   endtask

   task automatic t_irq_clear;
      @(negedge cpu_clk);
      irq_clr = 2'b01;
      @(negedge cpu_clk);
      irq_clr = 2'b00;
      chk(sync_irq == 2'b10, "R7 clear one bit", 32'(sync_irq), 2);
      @(negedge cpu_clk);
      irq_clr = 2'b10;
      @(negedge cpu_clk);
      irq_clr = 2'b00;
      chk(sync_irq == 2'b00, "R7 clear other", 32'(sync_irq), 0);
   endtask

   task automatic t_queued;
      tick_en = 0;
      do_write(4'd0, 16'h1111);
      wait_pending_low(0);
      do_write(4'd0, 16'h2222);
      chk(wr_pending[0] && !wr_reject && !wr_synced[0], "R9 queued accepted",
          32'({wr_pending[0], wr_reject, wr_synced[0]}), 4);
      tick_en = 1;
      wait_synced(0);
      chk(mir(0) == 16'h2222 && sval(0) == 16'h2222, "R9 newer value", 32'(mir(0)), 32'h2222);
   endtask

   task automatic t_out_of_range;
      do_write(4'd5, 16'hDEAD);
      chk(wr_pending == 2'b00 && !wr_reject && wr_synced == 2'b11, "R10 ignored",
          32'({wr_pending, wr_reject, wr_synced}), 3);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge cpu_clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge cpu_clk);
      t_reset;
      cpu_rst_n = 1; slow_rst_n = 1;
      repeat (3) @(negedge cpu_clk);
      t_reset;
      t_basic;
      t_reject;
      t_tick_hold;
      t_irq_clear;
      t_queued;
      t_out_of_range;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule